// File: doc/BRIEF.md
# Pattern Vector Address Sequencer

This block walks the read address of a vector pattern memory, one address per test clock, and turns each returned pattern word into per-channel drive data and drive enables. Each stored word holds both the values for every channel and the direction of every channel. The direction of a pin can therefore change from one vector to the next. The block reads at most one address per clock, and the memory port is an ordinary synchronous RAM with one cycle of read latency.

A small register file is written through a single-cycle write port and sets the mode and four addresses: start, range end, halt and pause. There are three walk modes. Run-once stops after the top address. Loop-all wraps from the top address to zero. Range-loop wraps from the range end back to the start address. A programmed halt address ends the run, and a programmed pause address suspends it until a resume pulse arrives. Start, resume and abort are single-cycle pulses. The status outputs report the idle, running, paused and halted states and the live program counter in every state.

Top module: `pattern_sequencer`

## Requirements
- R1: After reset the block is idle. The program counter is 0, and mem_rd, cfg_err, vec_valid and pin_oe are all 0.
- R2: The register write port decodes cfg_addr as follows. 0 is the mode in bits 1:0 (0 run-once, 1 loop-all, 2 range-loop, 3 behaves as run-once). 1 is the start address. 2 is the range end. 3 is the halt address. 4 is the pause address. 5 holds the enables (bit 0 halt, bit 1 pause). A start pulse in the idle or halted state loads the program counter with the start address. That address is issued in the next cycle, and one incrementing address follows per clock. Exactly one status flag is high at any time, and a start pulse while running or paused has no effect.
- R3: In run-once mode, after the address 2^AW-1 is issued, the block halts.
- R4: With halt enabled, the vector at the halt address is issued exactly once. The block then halts, holding that address in the program counter. If the halt and pause addresses are equal, the halt takes effect.
- R5: With pause enabled, the vector at the pause address is issued once. The block then pauses with mem_rd low and the counter held. A resume pulse restarts issue at the following address in the next cycle.
- R6: In loop-all mode, address 2^AW-1 is followed by address 0. The block never stops by itself.
- R7: In range-loop mode, the range end address is followed by the start address.
- R8: A start pulse in range-loop mode with the range end below the start address sets cfg_err, and the block stays in its idle or halted state. The next accepted start clears cfg_err.
- R9: An abort pulse returns the block to idle from any state in the next cycle. It takes precedence over a start or resume in the same cycle.
- R10: vec_valid is high exactly one cycle after mem_rd. While vec_valid is high, pin_out equals bits CH-1:0 of mem_rdata and pin_oe equals bits 2*CH-1:CH. Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| start | input | 1 | Start pulse |
| resume | input | 1 | Resume pulse |
| abort | input | 1 | Abort pulse |
| mem_addr | output | AW | Pattern memory read address |
| mem_rd | output | 1 | Pattern memory read strobe |
| mem_rdata | input | 2*CH | Pattern word: high half enables, low half data |
| vec_valid | output | 1 | Pattern word on the pins is valid |
| pin_out | output | CH | Channel drive values |
| pin_oe | output | CH | Channel drive enables |
| st_idle | output | 1 | Idle status |
| st_running | output | 1 | Running status |
| st_paused | output | 1 | Paused status |
| st_halted | output | 1 | Halted status |
| pc | output | AW | Program counter |
| cfg_err | output | 1 | Range configuration error |

## Verification
Two events can fall in the same cycle. One is a halt match and a pause match on the same address. The other is an abort arriving in the same cycle as a start or a resume. The bench provokes the first by programming equal halt and pause addresses and then checking that the run ends halted, with that vector issued once. It provokes the second by pulsing abort together with start while idle, and together with resume while paused, and then checking that the block reports idle and issues no further address. The halt and range sweeps compare every issued address against an index computed from the start, end and halt values.

// File: rtl/pattern_sequencer.sv
module pattern_sequencer #(
  parameter int AW = 6,
  parameter int CH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          start,
  input  logic          resume,
  input  logic          abort,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [2*CH-1:0] mem_rdata,
  output logic          vec_valid,
  output logic [CH-1:0] pin_out,
  output logic [CH-1:0] pin_oe,
  output logic          st_idle,
  output logic          st_running,
  output logic          st_paused,
  output logic          st_halted,
  output logic [AW-1:0] pc,
  output logic          cfg_err
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PAUSE, S_HALT} state_t;
  state_t state;

  logic [1:0]    mode;
  logic [AW-1:0] rstart, rend, haddr, paddr;
  logic          halt_en, pause_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0; rstart <= '0; rend <= '0; haddr <= '0; paddr <= '0;
      halt_en <= 1'b0; pause_en <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: mode   <= cfg_wdata[1:0];
        3'd1: rstart <= cfg_wdata;
        3'd2: rend   <= cfg_wdata;
        3'd3: haddr  <= cfg_wdata;
        3'd4: paddr  <= cfg_wdata;
        3'd5: begin halt_en <= cfg_wdata[0]; pause_en <= cfg_wdata[1]; end
        default: ;
      endcase
    end
  end

  wire range_mode = (mode == 2'd2);
  wire loop_all   = (mode == 2'd1);
  wire once       = !range_mode && !loop_all;
  wire [AW-1:0] nxt = (range_mode && pc == rend) ? rstart : pc + 1'b1;
  wire at_end     = once && (pc == LAST);
  wire halt_hit   = halt_en && (pc == haddr);
  wire pause_hit  = pause_en && (pc == paddr);
  wire bad_range  = range_mode && (rend < rstart);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; pc <= '0; cfg_err <= 1'b0;
    end else if (abort) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE, S_HALT:
          if (start) begin
            if (bad_range) cfg_err <= 1'b1;
            else begin cfg_err <= 1'b0; pc <= rstart; state <= S_RUN; end
          end
        S_RUN:
          if (halt_hit)       state <= S_HALT;
          else if (pause_hit) state <= S_PAUSE;
          else if (at_end)    state <= S_HALT;
          else                pc <= nxt;
        S_PAUSE:
          if (resume) begin
            if (at_end) state <= S_HALT;
            else begin pc <= nxt; state <= S_RUN; end
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_valid <= 1'b0;
    else        vec_valid <= mem_rd;
  end

  assign mem_rd     = (state == S_RUN);
  assign mem_addr   = pc;
  assign pin_out    = vec_valid ? mem_rdata[CH-1:0]    : '0;
  assign pin_oe     = vec_valid ? mem_rdata[2*CH-1:CH] : '0;
  assign st_idle    = (state == S_IDLE);
  assign st_running = (state == S_RUN);
  assign st_paused  = (state == S_PAUSE);
  assign st_halted  = (state == S_HALT);
endmodule

module pattern_sequencer_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          resume,
  input logic          abort,
  input logic          mem_rd,
  input logic          vec_valid,
  input logic          st_idle,
  input logic          st_running,
  input logic          st_paused,
  input logic          st_halted,
  input logic [AW-1:0] pc,
  input logic          cfg_err,
  input logic [1:0]    mode,
  input logic [AW-1:0] rstart,
  input logic [AW-1:0] rend,
  input logic [AW-1:0] haddr,
  input logic [AW-1:0] paddr,
  input logic          halt_en,
  input logic          pause_en
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  p_one_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_idle, st_running, st_paused, st_halted}));

  p_once_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_running && mode == 2'd0 && pc == LAST && !abort |=> !st_running);

  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_running && halt_en && pc == haddr && !abort |=> st_halted && pc == $past(pc));

  p_pause_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_paused && !resume && !abort |=> st_paused && $stable(pc));

  p_resume_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_paused && resume && !abort && mode == 2'd1 |=>
      st_running && pc == AW'($past(pc) + 1'b1));

  p_wrap_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_running && mode == 2'd1 && pc == LAST && !(halt_en && pc == haddr) &&
    !(pause_en && pc == paddr) && !abort |=> st_running && pc == '0);

  p_range_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_running && mode == 2'd2 && pc == rend && !(halt_en && pc == haddr) &&
    !(pause_en && pc == paddr) && !abort |=> st_running && pc == $past(rstart));

  p_bad_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && start && !abort && mode == 2'd2 && rend < rstart |=> st_idle && cfg_err);

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> st_idle && !mem_rd);

  p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> vec_valid);

  p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |=> !vec_valid);
endmodule

bind pattern_sequencer pattern_sequencer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .abort(abort),
  .mem_rd(mem_rd), .vec_valid(vec_valid), .st_idle(st_idle),
  .st_running(st_running), .st_paused(st_paused), .st_halted(st_halted),
  .pc(pc), .cfg_err(cfg_err), .mode(mode), .rstart(rstart), .rend(rend),
  .haddr(haddr), .paddr(paddr), .halt_en(halt_en), .pause_en(pause_en)
);

// File: tb/tb_pattern_sequencer.sv
module tb_pattern_sequencer;
  localparam int AW = 6;
  localparam int CH = 4;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic start = 1'b0, resume = 1'b0, abort = 1'b0;
  logic [AW-1:0] mem_addr, pc;
  logic mem_rd, vec_valid, st_idle, st_running, st_paused, st_halted, cfg_err;
  logic [2*CH-1:0] ram_q;
  logic [CH-1:0] pin_out, pin_oe;

  int checks = 0, fails = 0;
  int got[$];

  always #5 clk = ~clk;

  pattern_sequencer #(.AW(AW), .CH(CH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .resume(resume), .abort(abort),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(ram_q),
    .vec_valid(vec_valid), .pin_out(pin_out), .pin_oe(pin_oe),
    .st_idle(st_idle), .st_running(st_running), .st_paused(st_paused),
    .st_halted(st_halted), .pc(pc), .cfg_err(cfg_err));

  function automatic logic [2*CH-1:0] pat(input logic [AW-1:0] a);
    return {a[3:0] ^ 4'h5, a[5:2] + 4'd3};
  endfunction

  always_ff @(posedge clk) if (mem_rd) ram_q <= pat(mem_addr);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = AW'(d);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_start();  @(negedge clk); start = 1'b1;  @(negedge clk); start = 1'b0;  endtask
  task automatic pulse_resume(); @(negedge clk); resume = 1'b1; @(negedge clk); resume = 1'b0; endtask
  task automatic pulse_abort();  @(negedge clk); abort = 1'b1;  @(negedge clk); abort = 1'b0;  endtask

  // sample at the current falling edge, then one per cycle, until not running or maxv vectors
  task automatic collect(input int maxv);
    bit prev_rd = 1'b0;
    logic [AW-1:0] prev_a = '0;
    got.delete();
    for (int c = 0; c < 400; c++) begin
      if (prev_rd)
        chk(vec_valid && pin_out == pat(prev_a)[CH-1:0] && pin_oe == pat(prev_a)[2*CH-1:CH],
            "R10 pins", int'({pin_oe, pin_out}), int'(pat(prev_a)));
      else
        chk(!vec_valid && pin_oe == '0, "R10 idle pins", int'(pin_oe), 0);
      if (!mem_rd) break;
      got.push_back(int'(mem_addr));
      prev_rd = 1'b1; prev_a = mem_addr;
      if (got.size() == maxv) break;
      @(negedge clk);
    end
  endtask

  task automatic seq_chk(input string tag, input int s, input int len, input int n);
    int bad = -1;
    if (got.size() != n) chk(0, {tag, " count"}, got.size(), n);
    else begin
      foreach (got[k]) if (bad < 0 && got[k] != s + (k % len)) bad = k;
      if (bad < 0) chk(1, tag, 0, 0);
      else chk(0, tag, got[bad], s + (bad % len));
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(st_idle && !mem_rd && pc == 0 && !cfg_err && !vec_valid && pin_oe == 0,
        "R1 reset", int'(pc), 0);
    rst_n = 1'b1;

    // R3 run-once to the top address, halt disabled
    wr(0, 0); wr(1, 60); wr(5, 0);
    pulse_start(); collect(400);
    seq_chk("R3 run-once", 60, 1000, 4);
    @(negedge clk);
    chk(st_halted && pc == TOP, "R3 halted at top", int'(pc), TOP);

    // R4 exhaustive halt address sweep from 0
    wr(1, 0); wr(5, 1);
    for (int h = 0; h <= TOP; h++) begin
      wr(3, h);
      pulse_start(); collect(400);
      seq_chk("R4 halt sweep", 0, 1000, h + 1);
      @(negedge clk);
      chk(st_halted && pc == AW'(h), "R4 halted pc", int'(pc), h);
    end

    // R5 pause then resume; R2 start ignored while paused/running
    wr(1, 5); wr(3, 12); wr(4, 9); wr(5, 3);
    pulse_start(); collect(400);
    seq_chk("R5 to pause", 5, 1000, 5);
    repeat (3) @(negedge clk);
    chk(st_paused && !mem_rd && pc == 9, "R5 paused hold", int'(pc), 9);
    pulse_start();
    chk(st_paused && pc == 9, "R2 start ignored while paused", int'(pc), 9);
    pulse_resume(); collect(400);
    seq_chk("R5 after resume", 10, 1000, 3);
    @(negedge clk);
    chk(st_halted && pc == 12, "R4 halt after resume", int'(pc), 12);

    // R4 halt and pause on the same address: halt wins
    wr(1, 2); wr(3, 7); wr(4, 7);
    pulse_start(); collect(400);
    seq_chk("R4 same address", 2, 1000, 6);
    @(negedge clk);
    chk(st_halted && !st_paused, "R4 halt beats pause", int'(st_paused), 0);

    // R6 loop-all wrap
    wr(0, 1); wr(5, 0); wr(1, 61);
    pulse_start(); collect(9);
    if (got.size() == 9) begin
      int bad = -1;
      foreach (got[k]) if (bad < 0 && got[k] != ((61 + k) % (TOP + 1))) bad = k;
      chk(bad < 0, "R6 loop-all wrap", bad < 0 ? 0 : got[bad], bad < 0 ? 0 : (61 + bad) % (TOP + 1));
    end else chk(0, "R6 count", got.size(), 9);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    chk(st_running, "R2 start ignored while running", int'(st_running), 1);
    pulse_abort();
    chk(st_idle && !mem_rd, "R9 abort from running", int'(st_idle), 1);

    // R7 range-loop sweep
    wr(0, 2);
    foreach (got[k]) got[k] = got[k];
    for (int si = 0; si < 4; si++) begin
      for (int ei = 0; ei < 4; ei++) begin
        int s, e, len;
        s = (si == 0) ? 0 : (si == 1) ? 7 : (si == 2) ? 20 : 58;
        e = (ei == 0) ? s : (ei == 1) ? s + 1 : (ei == 2) ? s + 5 : TOP;
        if (e > TOP) e = TOP;
        len = e - s + 1;
        wr(1, s); wr(2, e);
        pulse_start(); collect(3 * len + 1);
        seq_chk("R7 range loop", s, len, 3 * len + 1);
        pulse_abort();
        chk(st_idle, "R9 abort range", int'(st_idle), 1);
      end
    end

    // R8 bad range refused, then cleared
    wr(1, 10); wr(2, 5);
    pulse_start();
    chk(st_idle && cfg_err && !mem_rd, "R8 bad range refused", int'(cfg_err), 1);
    wr(2, 20);
    pulse_start();
    chk(st_running && !cfg_err && pc == 10, "R8 error cleared", int'(pc), 10);
    pulse_abort();

    // R9 abort with start in the same cycle while idle
    @(negedge clk); abort = 1'b1; start = 1'b1;
    @(negedge clk); abort = 1'b0; start = 1'b0;
    chk(st_idle && !mem_rd, "R9 abort beats start", int'(st_idle), 1);

    // R9 abort with resume in the same cycle while paused
    wr(0, 1); wr(1, 30); wr(4, 33); wr(5, 2);
    pulse_start(); collect(400);
    seq_chk("R5 pause loop-all", 30, 1000, 4);
    @(negedge clk); abort = 1'b1; resume = 1'b1;
    @(negedge clk); abort = 1'b0; resume = 1'b0;
    chk(st_idle && !mem_rd && pc == 33, "R9 abort beats resume", int'(pc), 33);
    repeat (2) @(negedge clk);
    chk(!vec_valid && pin_oe == 0, "R10 pins off when idle", int'(pin_oe), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule